// File: doc/BRIEF.md
# Approximate 8x8 Multiplier with Selectable Column Summation

This block multiplies two unsigned 8-bit operands and returns a 16-bit product that may differ from the exact one by a small, known amount. Each operand is split into a low and a high nibble, and four approximate 4x4 sub-multipliers form the products of the nibble pairs. The sub-products are then combined by a fixed column scheme. A compile-time parameter picks one of two ways of combining them. The first adds the sub-products exactly, carries included. The second forms each column without any carry from the column below, which shortens the path and costs accuracy.

Each approximate 4x4 sub-multiplier builds its result from two 4x2 partial products. It drops the combination of carries into bit 3 that a single LUT-and-carry-chain slice cannot resolve. The result is low by exactly 8 for six of the 256 operand pairs and exact for all the others. The product is registered, so it appears one clock after the operands. It is meant for error-tolerant datapaths such as image filters, where area and path length matter more than the last bits.

Top module: `amul_mul8x8`

## Requirements
- R1: While `rst` is high at a rising clock edge, `prod` becomes 0 at that edge and stays 0 until an edge with `rst` low.
- R2: `prod` after a rising edge with `rst` low is the result for the `op_a`/`op_b` sampled at that edge, so the latency is one clock.
- R3: Product bits 2:0 always equal bits 2:0 of the exact product, in both summation modes.
- R4: The 4x4 sub-multiplier for nibbles x, y returns x*y minus 8 when x[0], y[2], bits 2 and 3 of x*y[1:0], and bit 1 of x*y[3:2] are all 1. Otherwise it returns x*y exactly. This error occurs for six (x, y) pairs, among them x=15, y=5, which gives 67.
- R5: With MODE=0, `prod` equals PP0 + 16*PP1 + 16*PP2 + 256*PP3. Here PP0 is the sub-product of the low nibbles, PP1 is high `op_a` times low `op_b`, PP2 is low `op_a` times high `op_b`, and PP3 is the high nibbles. It never exceeds the exact product.
- R6: With MODE=0, over all 65536 operand pairs there are exactly 5482 wrong products. The largest error is 2312 and occurs 14 times, and the summed absolute error is 3551232, an average of 54.1875.
- R7: With MODE=1, bits 3:0 are PP0[3:0]. Bit 4+k is PP0[4+k] XOR PP1[k] XOR PP2[k], and bit 8+k is PP1[4+k] XOR PP2[4+k] XOR PP3[k], for k in 0..3.
- R8: With MODE=1, bits 15:12 are PP3[7:4] with no carry in, so they never exceed the top nibble of the exact high-nibble product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | Unsigned operand A |
| op_b | input | 8 | Unsigned operand B |
| prod | output | 16 | Registered approximate product |

## Verification
The assertions assume that `op_a` and `op_b` hold known values at every rising edge with `rst` low. They also assume the operands are stable around that edge, so the sample taken one clock earlier is the one the product belongs to. The bench meets both assumptions. It changes the operands only on falling edges and always drives defined values. It walks the whole operand space once, in order, so every error case of both modes is covered without any random choice.

// File: rtl/amul_pkg.sv
package amul_pkg;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 2 * NIB_W;
  localparam int PROD_W = 2 * OP_W;
  localparam int SUB_W  = 2 * NIB_W;
  localparam int NUM_PP = 4;
  localparam int SUM_CARRY = 0;
  localparam int SUM_XOR   = 1;
endpackage

// File: rtl/amul_mul4x2.sv
module amul_mul4x2 #(
  parameter int A_W = 4,
  parameter int B_W = 2,
  localparam int P_W = A_W + B_W
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [P_W-1:0] p
);
  logic [P_W-1:0] row [B_W];

  for (genvar r = 0; r < B_W; r++) begin : g_row
    assign row[r] = ({{B_W{1'b0}}, a} & {P_W{b[r]}}) << r;
  end

  always_comb begin
    p = '0;
    for (int r = 0; r < B_W; r++) p = p + row[r];
  end
endmodule

// File: rtl/amul_mul4x4.sv
module amul_mul4x4
  import amul_pkg::*;
(
  input  logic [NIB_W-1:0] x,
  input  logic [NIB_W-1:0] y,
  output logic [SUB_W-1:0] p
);
  localparam int HALF_W = NIB_W / 2;
  localparam int PART_W = NIB_W + HALF_W;

  logic [PART_W-1:0] lo, hi;
  logic c2, c3, s3;
  logic [3:0] upper;

  amul_mul4x2 #(.A_W(NIB_W), .B_W(HALF_W)) lo_i (.a(x), .b(y[HALF_W-1:0]),     .p(lo));
  amul_mul4x2 #(.A_W(NIB_W), .B_W(HALF_W)) hi_i (.a(x), .b(y[NIB_W-1:HALF_W]), .p(hi));

  // bit 2 exact; bit 3 loses its value when all three inputs are set (-8)
  assign c2 = lo[2] & hi[0];
  assign s3 = (lo[3] ^ hi[1] ^ c2) & ~(lo[3] & hi[1] & c2);
  assign c3 = (lo[3] & hi[1]) | (lo[3] & c2) | (hi[1] & c2);
  assign upper = {2'b00, lo[5:4]} + hi[5:2] + {3'b000, c3};

  assign p = {upper, s3, lo[2] ^ hi[0], lo[1:0]};
endmodule

// File: rtl/amul_colsum.sv
module amul_colsum
  import amul_pkg::*;
#(
  parameter int MODE = SUM_CARRY
) (
  input  logic [SUB_W-1:0]  pp0,
  input  logic [SUB_W-1:0]  pp1,
  input  logic [SUB_W-1:0]  pp2,
  input  logic [SUB_W-1:0]  pp3,
  output logic [PROD_W-1:0] sum
);
  if (MODE == SUM_CARRY) begin : g_carry
    assign sum = {{OP_W{1'b0}}, pp0}
               + {{NIB_W{1'b0}}, pp1, {NIB_W{1'b0}}}
               + {{NIB_W{1'b0}}, pp2, {NIB_W{1'b0}}}
               + {pp3, {OP_W{1'b0}}};
  end else begin : g_xor
    assign sum[NIB_W-1:0]         = pp0[NIB_W-1:0];
    assign sum[2*NIB_W-1:NIB_W]   = pp0[SUB_W-1:NIB_W] ^ pp1[NIB_W-1:0] ^ pp2[NIB_W-1:0];
    assign sum[3*NIB_W-1:2*NIB_W] = pp1[SUB_W-1:NIB_W] ^ pp2[SUB_W-1:NIB_W] ^ pp3[NIB_W-1:0];
    assign sum[4*NIB_W-1:3*NIB_W] = pp3[SUB_W-1:NIB_W];
  end
endmodule

// File: rtl/amul_mul8x8.sv
module amul_mul8x8
  import amul_pkg::*;
#(
  parameter int MODE = SUM_CARRY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [PROD_W-1:0] prod
);
  logic [SUB_W-1:0]  pp [NUM_PP];
  logic [PROD_W-1:0] sum;

  // index bit 0 picks the high nibble of op_a, bit 1 the high nibble of op_b
  for (genvar i = 0; i < NUM_PP; i++) begin : g_sub
    logic [NIB_W-1:0] xs, ys;
    assign xs = (i % 2 == 1) ? op_a[OP_W-1:NIB_W] : op_a[NIB_W-1:0];
    assign ys = (i / 2 == 1) ? op_b[OP_W-1:NIB_W] : op_b[NIB_W-1:0];
    amul_mul4x4 sub_i (.x(xs), .y(ys), .p(pp[i]));
  end

  amul_colsum #(.MODE(MODE)) sum_i (
    .pp0(pp[0]), .pp1(pp[1]), .pp2(pp[2]), .pp3(pp[3]), .sum(sum)
  );

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= sum;
  end
endmodule

// File: rtl/amul_mul8x8_chk.sv
module amul_mul8x8_chk
  import amul_pkg::*;
#(
  parameter int MODE = SUM_CARRY
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic [PROD_W-1:0] prod
);
  logic [PROD_W-1:0] exact;
  logic [5:0]        low_exact;
  logic [SUB_W-1:0]  hh_exact;

  assign exact     = {{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b};
  assign low_exact = {3'b000, op_a[2:0]} * {3'b000, op_b[2:0]};
  assign hh_exact  = {{NIB_W{1'b0}}, op_a[OP_W-1:NIB_W]} * {{NIB_W{1'b0}}, op_b[OP_W-1:NIB_W]};

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> prod == '0);

  assert_low_bits_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prod[2:0] == $past(low_exact[2:0]));

  if (MODE == SUM_CARRY) begin : g_carry
    assert_not_above_R5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> prod <= $past(exact));
    assert_err_bound_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ($past(exact) - prod) <= 16'd2312);
  end else begin : g_xor
    assert_top_nibble_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> prod[PROD_W-1:PROD_W-NIB_W] <= $past(hh_exact[SUB_W-1:NIB_W]));
  end
endmodule

bind amul_mul8x8 amul_mul8x8_chk #(.MODE(MODE)) chk_i (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod(prod)
);

// File: tb/amul_mul8x8_tb_top.sv
`timescale 1ns/1ps
module amul_mul8x8_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] op_a = 8'd0, op_b = 8'd0;
  logic [15:0] prod_c, prod_x;
  int n_checks = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  amul_mul8x8 #(.MODE(0)) dut_i   (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod(prod_c));
  amul_mul8x8 #(.MODE(1)) dut_x_i (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod(prod_x));

  function automatic int sub4(int x, int y);
    int l, h;
    l = x * (y % 4);
    h = x * (y / 4);
    if ((x % 2 == 1) && ((y / 4) % 2 == 1) && ((l / 4) % 2 == 1) &&
        ((l / 8) % 2 == 1) && ((h / 2) % 2 == 1))
      return x * y - 8;
    return x * y;
  endfunction

  function automatic int model(int a, int b, int mode);
    int p0, p1, p2, p3, r;
    p0 = sub4(a % 16, b % 16);
    p1 = sub4(a / 16, b % 16);
    p2 = sub4(a % 16, b / 16);
    p3 = sub4(a / 16, b / 16);
    if (mode == 0) return p0 + 16 * p1 + 16 * p2 + 256 * p3;
    r = p0 % 16;
    for (int k = 0; k < 4; k++) begin
      r += ((((p0 >> (4 + k)) ^ (p1 >> k) ^ (p2 >> k)) & 1) << (4 + k));
      r += ((((p1 >> (4 + k)) ^ (p2 >> (4 + k)) ^ (p3 >> k)) & 1) << (8 + k));
      r += (((p3 >> (4 + k)) & 1) << (12 + k));
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int exp_c_q[$], exp_x_q[$], ab_q[$];

  initial begin
    int nerr, maxe, maxn, tot, small_err;
    nerr = 0; maxe = 0; maxn = 0; tot = 0; small_err = 0;
    // R1: reset holds the product at zero
    op_a = 8'hFF; op_b = 8'hFF;
    repeat (2) @(negedge clk);
    check(prod_c == 16'd0, "R1 carry reset", prod_c, 0);
    check(prod_x == 16'd0, "R1 nocarry reset", prod_x, 0);
    rst = 1'b0;
    for (int idx = 0; idx <= 65536; idx++) begin
      if (idx > 0) @(negedge clk);
      if (exp_c_q.size() > 0) begin
        int ec, ex, ab, a, b, ext, e;
        ec = exp_c_q.pop_front(); ex = exp_x_q.pop_front(); ab = ab_q.pop_front();
        a = ab % 256; b = ab / 256; ext = a * b;
        // R2, R5: carry mode one clock later equals the weighted sub-product sum
        check(int'(prod_c) == ec, "R5 carry value", prod_c, ec);
        // R7: no-carry column XOR scheme
        check(int'(prod_x) == ex, "R7 nocarry value", prod_x, ex);
        // R3: bits 2:0 exact
        check(int'(prod_x[2:0]) == ext % 8, "R3 low bits", prod_x[2:0], ext % 8);
        // R8: top nibble carry-free
        check(int'(prod_x[15:12]) <= (sub4(a / 16, b / 16) / 16) + 0, "R8 top nibble",
              prod_x[15:12], sub4(a / 16, b / 16) / 16);
        e = ext - int'(prod_c);
        if (e != 0) nerr++;
        tot += (e < 0) ? -e : e;
        if (e > maxe) begin maxe = e; maxn = 1; end
        else if (e == maxe && e != 0) maxn++;
        // R4: nibble-only operands use just the low sub-multiplier
        if (a < 16 && b < 16 && e != 0) small_err++;
        if (a == 15 && b == 5)
          check(prod_c == 16'd67, "R4 15x5", prod_c, 67);
      end
      if (idx < 65536) begin
        op_a = idx[7:0]; op_b = idx[15:8];
        exp_c_q.push_back(model(idx % 256, idx / 256, 0));
        exp_x_q.push_back(model(idx % 256, idx / 256, 1));
        ab_q.push_back(idx);
      end
    end
    check(small_err == 6, "R4 sub-multiplier error pairs", small_err, 6);
    check(nerr == 5482, "R6 error count", nerr, 5482);
    check(maxe == 2312, "R6 max error", maxe, 2312);
    check(maxn == 14, "R6 max error count", maxn, 14);
    check(tot == 3551232, "R6 total abs error", tot, 3551232);
    // R1: reset mid-run clears a nonzero product
    op_a = 8'd200; op_b = 8'd100;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(prod_c == 16'd0, "R1 carry reset mid-run", prod_c, 0);
    check(prod_x == 16'd0, "R1 nocarry reset mid-run", prod_x, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule